// File: doc/BRIEF.md
# High-Side Switch and Bootstrap Recharge Sequencer

This block is a clocked controller for a floating high-side power switch and the recharge switch that refills its bootstrap capacitor. It takes an active-low switch command, an active-high enable, and two supply-good flags. One flag is for the logic supply and one is for the floating supply. Both flags come from comparators with hysteresis outside this block. The block drives two registered requests: one for the high-side gate and one for the recharge switch.

The two switches must never conduct together. The block therefore inserts two deadtimes, each counted in clock cycles and set by a parameter.

- After the high side drops, there is a long wait before recharge may start. The default is 110 cycles, which is 11 µs at 10 MHz.
- After recharge drops, there is a short wait before the high side may start. The default is 8 cycles.

Supply and enable gating follow a fixed table. In it, a low floating supply with a valid turn-on request parks both switches off.

Top module: `hs_deadtime_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `hs_on` becomes 0 and `rech_on` becomes 1.
- R2: If at an edge any of `logic_ok`, `float_ok` or `enable` is low, or `cmd_n` is high, then `hs_on` is 0 after that edge. This cancels any pending turn-on.
- R3: `hs_on` rises only when recharge has been low for at least `DT_HS` edges before it. With a constant turn-on request starting from recharge on, `rech_on` falls at the first edge and `hs_on` rises `DT_HS` edges later.
- R4: `rech_on` rises only when `hs_on` has been low for at least `DT_REC` edges before it. After a turn-off, `rech_on` rises exactly `DT_REC` edges after `hs_on` falls.
- R5: `hs_on` and `rech_on` are never 1 in the same cycle.
- R6: While `logic_ok`=1, `float_ok`=0, `enable`=1 and `cmd_n`=0, both outputs are 0 from the next edge on.
- R7: While `logic_ok`=0, `enable`=0 or `cmd_n`=1, `rech_on` is 1 after the edge at which the R4 wait is complete. If the high side has been off at least `DT_REC` edges, this is the next edge.
- R8: If the turn-on request is withdrawn before the high-side deadtime ends, `hs_on` stays 0. `rech_on` returns at the next edge when the high side has been off long enough.
- R9: A new turn-on request after recharge has turned on again restarts the high-side wait from the new recharge fall. If recharge never turned on since the high side fell, the high side may return at the next edge.
- R10: A valid turn-on request at an edge (both supplies good, `enable`=1, `cmd_n`=0) makes `rech_on` 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_n | input | 1 | Switch command, 0 requests high side on |
| enable | input | 1 | 1 allows the high side to turn on |
| logic_ok | input | 1 | Logic supply above threshold |
| float_ok | input | 1 | Floating supply above threshold |
| hs_on | output | 1 | High-side gate request |
| rech_on | output | 1 | Recharge switch request |

## Verification
The assertions assume that all four control inputs are synchronous to `clk` and stable around each rising edge. The supply flags are assumed to be already debounced, so a single-cycle change is treated as a real supply event. The bench changes every input only on the falling edge. It holds each setting for whole cycles and lets every scenario return to the recharge state with the high side off for longer than `DT_REC`. This way each deadtime is measured from a known start.

// File: rtl/hs_deadtime_seq.sv
module hs_deadtime_seq #(
  parameter int unsigned DT_HS  = 8,
  parameter int unsigned DT_REC = 110
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_n,
  input  logic enable,
  input  logic logic_ok,
  input  logic float_ok,
  output logic hs_on,
  output logic rech_on
);

  localparam int HW = $clog2(DT_HS + 1);
  localparam int RW = $clog2(DT_REC + 1);
  localparam logic [HW-1:0] HS_LAST  = HW'(DT_HS - 1);
  localparam logic [RW-1:0] REC_LAST = RW'(DT_REC - 1);

  logic hs_q, rech_q;
  logic [HW-1:0] rech_off_cnt;
  logic [RW-1:0] hs_off_cnt;

  wire want_hs   = logic_ok & float_ok & enable & ~cmd_n;
  wire want_rech = ~logic_ok | ~enable | cmd_n;

  wire hs_gap_ok   = ~rech_q & (rech_off_cnt >= HS_LAST);
  wire rech_gap_ok = ~hs_q & (hs_off_cnt >= REC_LAST);

  wire hs_d   = want_hs & hs_gap_ok;
  wire rech_d = want_rech & rech_gap_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q         <= 1'b0;
      rech_q       <= 1'b1;
      hs_off_cnt   <= REC_LAST;
      rech_off_cnt <= '0;
    end else begin
      hs_q   <= hs_d;
      rech_q <= rech_d;
      if (hs_q)
        hs_off_cnt <= '0;
      else if (hs_off_cnt < REC_LAST)
        hs_off_cnt <= hs_off_cnt + 1'b1;
      if (rech_q)
        rech_off_cnt <= '0;
      else if (rech_off_cnt < HS_LAST)
        rech_off_cnt <= rech_off_cnt + 1'b1;
    end
  end

  assign hs_on   = hs_q;
  assign rech_on = rech_q;

  logic [HW:0] mon_rech_low;
  logic [RW:0] mon_hs_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      mon_rech_low <= '0;
      mon_hs_low   <= (RW+1)'(DT_REC);
    end else begin
      if (rech_on)
        mon_rech_low <= '0;
      else if (mon_rech_low < (HW+1)'(DT_HS))
        mon_rech_low <= mon_rech_low + 1'b1;
      if (hs_on)
        mon_hs_low <= '0;
      else if (mon_hs_low < (RW+1)'(DT_REC))
        mon_hs_low <= mon_hs_low + 1'b1;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!hs_on && rech_on));

  // R2
  hs_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !(logic_ok && float_ok && enable && !cmd_n) |=> !hs_on);

  // R3
  hs_deadtime_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_on) |-> (mon_rech_low >= (HW+1)'(DT_HS)));

  // R4
  rech_deadtime_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rech_on) |-> (mon_hs_low >= (RW+1)'(DT_REC)));

  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(hs_on && rech_on));

  // R6
  park_off_chk: assert property (@(posedge clk) disable iff (rst)
    (logic_ok && !float_ok && enable && !cmd_n) |=> (!hs_on && !rech_on));

  // R10
  rech_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (logic_ok && float_ok && enable && !cmd_n) |=> !rech_on);

endmodule

// File: tb/hs_deadtime_seq_bench.sv
module hs_deadtime_seq_bench;
  localparam int DT_HS  = 8;
  localparam int DT_REC = 110;

  logic clk = 1'b0;
  logic rst, cmd_n, enable, logic_ok, float_ok;
  logic hs_on, rech_on;
  int ckrun = 0;
  int ckfail = 0;

  always #10 clk = ~clk;

  hs_deadtime_seq #(.DT_HS(DT_HS), .DT_REC(DT_REC)) u_hs_deadtime_seq (
    .clk(clk), .rst(rst), .cmd_n(cmd_n), .enable(enable),
    .logic_ok(logic_ok), .float_ok(float_ok),
    .hs_on(hs_on), .rech_on(rech_on)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    ckrun++;
    if (act !== exp) begin
      ckfail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_in(input logic l, input logic f, input logic e, input logic c);
    logic_ok = l; float_ok = f; enable = e; cmd_n = c;
  endtask

  task automatic t_reset;
    chk("R1 hs", hs_on, 1'b0);
    chk("R1 rech", rech_on, 1'b1);
  endtask

  task automatic t_turn_on;
    set_in(1, 1, 1, 0);
    wait_n(1);
    chk("R10 rech drops", rech_on, 1'b0);
    chk("R3 hs waits", hs_on, 1'b0);
    wait_n(DT_HS - 1);
    chk("R3 hs still off", hs_on, 1'b0);
    wait_n(1);
    chk("R3 hs on", hs_on, 1'b1);
    chk("R5 rech off", rech_on, 1'b0);
  endtask

  task automatic t_turn_off;
    cmd_n = 1'b1;
    wait_n(1);
    chk("R2 hs off", hs_on, 1'b0);
    chk("R4 rech waits", rech_on, 1'b0);
    wait_n(DT_REC - 1);
    chk("R4 rech still off", rech_on, 1'b0);
    wait_n(1);
    chk("R4 rech on", rech_on, 1'b1);
  endtask

  task automatic t_disable;
    t_turn_on();
    enable = 1'b0;
    wait_n(1);
    chk("R2 enable low", hs_on, 1'b0);
    wait_n(DT_REC);
    chk("R7 rech after disable", rech_on, 1'b1);
  endtask

  task automatic t_uv;
    t_turn_on();
    logic_ok = 1'b0;
    wait_n(1);
    chk("R2 logic uv", hs_on, 1'b0);
    wait_n(DT_REC);
    chk("R7 rech in logic uv", rech_on, 1'b1);
    set_in(1, 0, 1, 0);
    wait_n(1);
    chk("R6 hs parked", hs_on, 1'b0);
    chk("R6 rech parked", rech_on, 1'b0);
    wait_n(20);
    chk("R6 still parked", hs_on | rech_on, 1'b0);
    float_ok = 1'b1;
    wait_n(1);
    chk("R3 hs after long rech low", hs_on, 1'b1);
    float_ok = 1'b0;
    wait_n(1);
    chk("R2 float uv", hs_on, 1'b0);
    wait_n(DT_REC + 5);
    chk("R6 both off after float uv", hs_on | rech_on, 1'b0);
    cmd_n = 1'b1;
    wait_n(1);
    chk("R7 rech on cmd high", rech_on, 1'b1);
  endtask

  task automatic t_quiet;
    for (int i = 0; i < 8; i++) begin
      set_in(i[2], i[1], i[0], 1'b1);
      if (i == 7) cmd_n = 1'b1;
      wait_n(1);
      chk("R7 recharge stays", rech_on, 1'b1);
      chk("R2 hs stays off", hs_on, 1'b0);
    end
    set_in(0, 1, 1, 0);
    wait_n(1);
    chk("R7 logic uv with request", rech_on, 1'b1);
    chk("R2 logic uv with request", hs_on, 1'b0);
    set_in(1, 1, 1, 1);
    wait_n(1);
  endtask

  task automatic t_cancel;
    set_in(1, 1, 1, 0);
    wait_n(3);
    chk("R8 hs pending", hs_on, 1'b0);
    cmd_n = 1'b1;
    wait_n(1);
    chk("R8 rech returns", rech_on, 1'b1);
    chk("R8 hs off", hs_on, 1'b0);
    wait_n(DT_HS);
    chk("R8 hs never rose", hs_on, 1'b0);
  endtask

  task automatic t_restart;
    set_in(1, 1, 1, 0);
    wait_n(3);
    cmd_n = 1'b1;
    wait_n(1);
    chk("R9 rech back", rech_on, 1'b1);
    cmd_n = 1'b0;
    wait_n(1);
    chk("R9 rech drops again", rech_on, 1'b0);
    wait_n(DT_HS - 1);
    chk("R9 wait restarted", hs_on, 1'b0);
    wait_n(1);
    chk("R9 hs on after restart", hs_on, 1'b1);
    t_turn_off();
  endtask

  task automatic t_rerequest;
    t_turn_on();
    cmd_n = 1'b1;
    wait_n(20);
    chk("R4 both off mid wait", hs_on | rech_on, 1'b0);
    cmd_n = 1'b0;
    wait_n(1);
    chk("R9 hs returns at once", hs_on, 1'b1);
    t_turn_off();
  endtask

  initial begin
    rst = 1'b1;
    set_in(0, 0, 0, 1);
    wait_n(3);
    t_reset();
    rst = 1'b0;
    set_in(1, 1, 1, 1);
    wait_n(2);
    t_reset();
    t_turn_on();
    t_turn_off();
    t_disable();
    t_uv();
    t_quiet();
    t_cancel();
    t_restart();
    t_rerequest();
    $display("[TB] %0d tests run, %0d failed", ckrun, ckfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    ckrun++;
    ckfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", ckrun, ckfail);
    $finish;
  end
endmodule